// File: doc/BRIEF.md
# Dual-Direction Mailbox Slave Port

This block lets an external master processor and a local processor pass bytes to each other without sharing a bus cycle. Each of three data addresses holds two one-way registers. The master writes the master-to-local register and reads the local-to-master register. The local side does the reverse. A shared status byte records which of the six registers hold unread data. It also records whether either side has a pending interrupt. Both sides can read the status byte.

The master side has a strobe-style bus: active-low chip select, read strobe and write strobe, a 2-bit address and 8-bit data. The block runs on the local clock. It passes each master strobe through a two-flop synchronizer and acts on the rising edge of the synchronized strobe. A store to data address zero interrupts the opposite side, and a read of address zero by that side clears the interrupt. A master write to address three stores nothing. It is a doorbell: the local side receives a one-cycle pulse and a sticky flag.

Top module: `mbox_port`

## Requirements
- R1: After reset, all six data registers are zero, the status byte is zero, and `m_irq`, `l_irq`, `l_sig_pulse` and `l_sig_sticky` are low.
- R2: A master write to address k (0..2) stores `m_wdata` into master-to-local register k. That register is then returned on `l_rdata` when `l_addr`=k, and status bit k is set. A master read of address k returns local-to-master register k on `m_rdata`, not the value the master wrote.
- R3: A local write (`l_wr`) to address k (0..2) stores `l_wdata` into local-to-master register k. That register is returned on `m_rdata` while `m_addr`=k, and status bit 4+k is set.
- R4: A local read (`l_rd`) of address k (0..2) clears status bit k. A master read strobe at address k clears status bit 4+k. Storing the same value again sets the bit again.
- R5: A local write to address 0 raises `m_irq` and status bit 7. A master read strobe at address 0 clears both.
- R6: A master write to address 0 sets status bit 3. `l_irq` equals status bit 3 ANDed with `l_irq_en`. A local read of address 0 clears bit 3.
- R7: A master write to address 3 changes no data register and no full flag. It produces `l_sig_pulse` high for exactly one cycle and sets `l_sig_sticky`. A local write to address 3 clears `l_sig_sticky`. A master read of address 3 has no side effect.
- R8: Each master strobe acts exactly once, on the third local rising clock edge after it becomes active (chip select and strobe both low). Holding the strobe longer has no further effect.
- R9: When a set and a clear of the same flag fall in the same cycle, the set wins. This covers a master write against a local read of the same register, a local write against a master read strobe, and a doorbell against a local clear of the sticky flag.
- R10: Address 3 reads the status byte on both `m_rdata` and `l_rdata`. The layout is: bits [2:0] master-to-local full flags, bit 3 local interrupt pending, bits [6:4] local-to-master full flags, bit 7 master interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cs_n | input | 1 | Master chip select, active low |
| m_rd_n | input | 1 | Master read strobe, active low |
| m_wr_n | input | 1 | Master write strobe, active low |
| m_addr | input | 2 | Master register address |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Master read data, combinational from `m_addr` |
| m_irq | output | 1 | Interrupt toward the master |
| l_addr | input | 2 | Local register address |
| l_rd | input | 1 | Local read, one cycle per access |
| l_wr | input | 1 | Local write, one cycle per access |
| l_wdata | input | DW | Local write data |
| l_rdata | output | DW | Local read data, combinational from `l_addr` |
| l_irq_en | input | 1 | Enables the local interrupt output |
| l_irq | output | 1 | Interrupt toward the local side |
| l_sig_pulse | output | 1 | One-cycle doorbell pulse |
| l_sig_sticky | output | 1 | Doorbell flag, cleared by a local write to address 3 |

## Verification
Two functions can act on the same flag in the same local clock cycle. One is a set that comes from the synchronized edge of a master strobe. The other is a clear from a local access: a local read of the register the master is writing, or a local write against a master read. The bench knows the strobe is applied on the third clock edge after it goes active. It places a one-cycle local access on exactly that edge for the write/read pair, the read/write pair and the doorbell/sticky-clear pair. It then judges the result by the status byte and the data register, where the set must win and the data must be the newly stored value.

// File: rtl/mbox_port.sv
module mbox_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_cs_n,
  input  logic          m_rd_n,
  input  logic          m_wr_n,
  input  logic [1:0]    m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          m_irq,
  input  logic [1:0]    l_addr,
  input  logic          l_rd,
  input  logic          l_wr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          l_irq_en,
  output logic          l_irq,
  output logic          l_sig_pulse,
  output logic          l_sig_sticky
);
  localparam int NREG = 3;
  localparam logic [1:0] STAT = 2'd3;

  logic [DW-1:0]   m2l [NREG];
  logic [DW-1:0]   l2m [NREG];
  logic [NREG-1:0] m2l_full, l2m_full;
  logic            m2l_pend, l2m_pend;
  logic [2:0]      wr_sync, rd_sync;
  logic            mw_edge, mr_edge;
  logic [7:0]      status;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sync <= '0;
      rd_sync <= '0;
    end else begin
      wr_sync <= {wr_sync[1:0], ~m_cs_n & ~m_wr_n};
      rd_sync <= {rd_sync[1:0], ~m_cs_n & ~m_rd_n};
    end

  assign mw_edge = wr_sync[1] & ~wr_sync[2];
  assign mr_edge = rd_sync[1] & ~rd_sync[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        m2l[i] <= '0;
        l2m[i] <= '0;
      end
      m2l_full     <= '0;
      l2m_full     <= '0;
      m2l_pend     <= 1'b0;
      l2m_pend     <= 1'b0;
      l_sig_pulse  <= 1'b0;
      l_sig_sticky <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (mw_edge && m_addr == 2'(i)) begin
          m2l[i]      <= m_wdata;
          m2l_full[i] <= 1'b1;
        end else if (l_rd && l_addr == 2'(i))
          m2l_full[i] <= 1'b0;
        if (l_wr && l_addr == 2'(i)) begin
          l2m[i]      <= l_wdata;
          l2m_full[i] <= 1'b1;
        end else if (mr_edge && m_addr == 2'(i))
          l2m_full[i] <= 1'b0;
      end
      if (mw_edge && m_addr == 2'd0)      m2l_pend <= 1'b1;
      else if (l_rd && l_addr == 2'd0)    m2l_pend <= 1'b0;
      if (l_wr && l_addr == 2'd0)         l2m_pend <= 1'b1;
      else if (mr_edge && m_addr == 2'd0) l2m_pend <= 1'b0;
      l_sig_pulse <= mw_edge && m_addr == STAT;
      if (mw_edge && m_addr == STAT)      l_sig_sticky <= 1'b1;
      else if (l_wr && l_addr == STAT)    l_sig_sticky <= 1'b0;
    end

  assign status = {l2m_pend, l2m_full, m2l_pend, m2l_full};
  assign m_irq  = l2m_pend;
  assign l_irq  = m2l_pend & l_irq_en;

  always_comb
    case (m_addr)
      2'd0:    m_rdata = l2m[0];
      2'd1:    m_rdata = l2m[1];
      2'd2:    m_rdata = l2m[2];
      default: m_rdata = DW'(status);
    endcase

  always_comb
    case (l_addr)
      2'd0:    l_rdata = m2l[0];
      2'd1:    l_rdata = m2l[1];
      2'd2:    l_rdata = m2l[2];
      default: l_rdata = DW'(status);
    endcase
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] m_addr,
  input logic [1:0] l_addr,
  input logic       l_wr,
  input logic       l_irq_en,
  input logic       l_irq,
  input logic       m_irq,
  input logic       l_sig_pulse,
  input logic       l_sig_sticky,
  input logic       mw_edge,
  input logic       mr_edge
);
  // R5
  m_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == 2'd0) |=> m_irq);
  // R5
  m_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_edge && m_addr == 2'd0 && !(l_wr && l_addr == 2'd0)) |=> !m_irq);
  // R6
  l_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_edge && m_addr == 2'd0) |=> (l_irq || !l_irq_en));
  // R7
  sig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_sig_pulse |=> !l_sig_pulse);
  // R9
  sig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_sig_pulse |-> l_sig_sticky);
endmodule

bind mbox_port mbox_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .l_addr(l_addr), .l_wr(l_wr),
  .l_irq_en(l_irq_en), .l_irq(l_irq), .m_irq(m_irq), .l_sig_pulse(l_sig_pulse),
  .l_sig_sticky(l_sig_sticky), .mw_edge(mw_edge), .mr_edge(mr_edge)
);

// File: tb/tb_mbox_port.sv
`timescale 1ns/1ps
module tb_mbox_port;
  logic clk = 0, rst_n = 0;
  logic m_cs_n = 1, m_rd_n = 1, m_wr_n = 1;
  logic [1:0] m_addr = 0, l_addr = 0;
  logic [7:0] m_wdata = 0, l_wdata = 0, m_rdata, l_rdata;
  logic l_rd = 0, l_wr = 0, l_irq_en = 0;
  logic m_irq, l_irq, l_sig_pulse, l_sig_sticky;

  mbox_port dut (.*);

  always #2 clk = ~clk;

  int vec = 0, bad = 0, pulses = 0;
  logic [7:0] mm [3];
  logic [7:0] lm [3];
  logic [2:0] mf = 0, lf = 0;
  logic mp = 0, lp = 0, stk = 0;

  always @(negedge clk) if (rst_n && l_sig_pulse) pulses++;

  function automatic logic [7:0] stat();
    return {lp, lf, mp, mf};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic chk_stat(string tag);
    logic [1:0] sv = m_addr;
    l_addr = 2'd3; m_addr = 2'd3; #1;
    chk(tag, l_rdata, stat());
    chk(tag, m_rdata, stat());
    chk({tag, " irq"}, {6'b0, m_irq, l_irq}, {6'b0, lp, mp & l_irq_en});
    chk({tag, " sticky"}, {7'b0, l_sig_sticky}, {7'b0, stk});
    m_addr = sv;
  endtask

  task automatic m_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); m_addr = a; m_wdata = d; m_cs_n = 0; m_wr_n = 0;
    repeat (4) @(negedge clk);
    m_cs_n = 1; m_wr_n = 1;
    repeat (3) @(negedge clk);
    if (a == 3) stk = 1;
    else begin mm[a] = d; mf[a] = 1; if (a == 0) mp = 1; end
  endtask

  task automatic m_read(logic [1:0] a, string tag);
    @(negedge clk); m_addr = a; m_cs_n = 0; m_rd_n = 0; #1;
    if (a != 3) chk(tag, m_rdata, lm[a]);
    repeat (4) @(negedge clk);
    m_cs_n = 1; m_rd_n = 1;
    repeat (3) @(negedge clk);
    if (a != 3) begin lf[a] = 0; if (a == 0) lp = 0; end
  endtask

  task automatic l_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); l_addr = a; l_wdata = d; l_wr = 1;
    @(negedge clk); l_wr = 0;
    if (a == 3) stk = 0;
    else begin lm[a] = d; lf[a] = 1; if (a == 0) lp = 1; end
  endtask

  task automatic l_read(logic [1:0] a, string tag);
    @(negedge clk); l_addr = a; l_rd = 1; #1;
    if (a != 3) chk(tag, l_rdata, mm[a]);
    @(negedge clk); l_rd = 0;
    if (a != 3) begin mf[a] = 0; if (a == 0) mp = 0; end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin mm[i] = 0; lm[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      l_addr = 2'(a); m_addr = 2'(a); #1;
      chk("R1 m2l reset", l_rdata, 8'h00);
      chk("R1 l2m reset", m_rdata, 8'h00);
    end
    chk_stat("R1 status reset");
    chk("R1 pulse reset", {7'b0, l_sig_pulse}, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R10 sweep
    for (int k = 0; k < 8; k++) begin
      for (int a = 0; a < 3; a++) begin
        logic [7:0] d = 8'(k * 37 + a * 11 + 1);
        l_irq_en = k[0];
        m_write(2'(a), d);
        l_addr = 2'(a); #1;
        chk("R2 m2l data", l_rdata, d);
        m_addr = 2'(a); #1;
        chk("R2 master reads l2m", m_rdata, lm[a]);
        chk_stat("R2 R6 R10 status after master write");
        l_write(2'(a), ~d);
        chk_stat("R3 R5 status after local write");
        m_read(2'(a), "R3 master read data");
        chk_stat("R4 R5 status after master read");
        l_read(2'(a), "R2 local read data");
        chk_stat("R4 R6 status after local read");
        m_write(2'(a), d);
        m_write(2'(a), d);
        chk_stat("R4 same value refills");
        l_read(2'(a), "R4 local reread");
        chk_stat("R4 cleared again");
      end
    end

    // R7 doorbell
    l_irq_en = 1;
    m_write(2'd1, 8'h3C);
    begin
      int p0 = pulses;
      m_write(2'd3, 8'hFF);
      chk("R7 one pulse", 8'(pulses - p0), 8'd1);
      l_addr = 2'd1; #1;
      chk("R7 data untouched", l_rdata, 8'h3C);
      chk_stat("R7 status after doorbell");
      p0 = pulses;
      m_write(2'd2, 8'h11);
      chk("R7 no pulse on data write", 8'(pulses - p0), 8'd0);
      m_read(2'd3, "R7 status read");
      chk_stat("R7 status read no effect");
      l_write(2'd3, 8'h00);
      chk_stat("R7 sticky cleared");
    end
    l_read(2'd1, "R7 drain1");
    l_read(2'd2, "R7 drain2");

    // R8 long strobe acts once
    @(negedge clk); m_addr = 2'd2; m_wdata = 8'h77; m_cs_n = 0; m_wr_n = 0;
    repeat (5) @(negedge clk);
    mm[2] = 8'h77; mf[2] = 1;
    l_read(2'd2, "R8 data during strobe");
    repeat (20) @(negedge clk);
    chk_stat("R8 no second set");
    m_cs_n = 1; m_wr_n = 1;
    repeat (3) @(negedge clk);
    chk_stat("R8 after release");

    // R9 master write vs local read, same cycle
    @(negedge clk); m_addr = 2'd1; m_wdata = 8'hC3; m_cs_n = 0; m_wr_n = 0;
    @(negedge clk);
    @(negedge clk); l_addr = 2'd1; l_rd = 1;
    @(negedge clk); l_rd = 0;
    @(negedge clk); m_cs_n = 1; m_wr_n = 1;
    repeat (3) @(negedge clk);
    mm[1] = 8'hC3; mf[1] = 1;
    chk_stat("R9 write beats local read");
    l_addr = 2'd1; #1;
    chk("R9 new data kept", l_rdata, 8'hC3);

    // R9 local write vs master read
    l_write(2'd2, 8'h5A);
    @(negedge clk); m_addr = 2'd2; m_cs_n = 0; m_rd_n = 0;
    @(negedge clk);
    @(negedge clk); l_addr = 2'd2; l_wdata = 8'hA6; l_wr = 1;
    @(negedge clk); l_wr = 0;
    @(negedge clk); m_cs_n = 1; m_rd_n = 1;
    repeat (3) @(negedge clk);
    lm[2] = 8'hA6; lf[2] = 1;
    chk_stat("R9 local write beats master read");
    m_addr = 2'd2; #1;
    chk("R9 l2m new data", m_rdata, 8'hA6);

    // R9 doorbell vs sticky clear
    @(negedge clk); m_addr = 2'd3; m_cs_n = 0; m_wr_n = 0;
    @(negedge clk);
    @(negedge clk); l_addr = 2'd3; l_wr = 1;
    @(negedge clk); l_wr = 0;
    @(negedge clk); m_cs_n = 1; m_wr_n = 1;
    repeat (3) @(negedge clk);
    stk = 1;
    chk_stat("R9 doorbell beats clear");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule